// File: doc/BRIEF.md
# Circular Buffer Pointer Wrap Unit

This block keeps address pointers inside a circular buffer in hardware, so that code running tight loops never has to test buffer boundaries itself. It holds two independent buffer contexts. Context 0 serves the X address space, which also supplies the pointers used for program-space fetches. Context 1 serves the Y space. Each context is programmed with a lower bound, an upper bound, an enable, a direction mode and the number of the pointer register it watches.

Each cycle a context may receive one pointer update: the register number, its current address, a step size and whether the step adds or subtracts. If the update targets the watched register and leaves the buffer in a direction that the context checks, the unit folds the excess back in from the opposite bound. Every other update is passed through as a plain add or subtract. The result comes out one clock cycle after the request.

A buffer normally checks one bound only. Bidirectional checking is allowed only when the buffer length (upper minus lower plus one) is a power of two. A context set to bidirectional with any other length is flagged as bad and does not wrap.

Top module: `circ_addr_unit`

## Requirements
- R1: Both contexts work independently. Slice c of every per-context port belongs to context c, with c=0 for X and c=1 for Y. res_valid_o[c] equals req_valid_i[c] one cycle later, and res_addr_o/res_wrapped_o hold the result of that request.
- R2: With upward checking active, an addition whose sum exceeds the upper bound produces lower + (sum - upper - 1). A sum equal to the upper bound is returned unchanged.
- R3: With downward checking active, a subtraction whose difference falls below the lower bound produces upper - (lower - difference - 1). A difference equal to the lower bound is returned unchanged.
- R4: cfg_mode_i encodes 2'b00 = upward only, 2'b01 = downward only, 2'b10 = both directions, 2'b11 = reserved. In a single-direction mode, a step in the other direction is passed through as addr plus or minus step, modulo 2^AW, with no wrap.
- R5: In mode 2'b10 with a power-of-two length, both bounds are checked.
- R6: cfg_bad_o[c] is high when an enabled context has upper < lower, mode 2'b11, or mode 2'b10 with a length that is not a power of two. A bad context passes every update through.
- R7: When cfg_en_i[c] is low, or req_reg_i does not equal cfg_sel_i for that context, the update is passed through.
- R8: cfg_warn_o[c] is high when cfg_en_i[c] is high and cfg_sel_i selects register 14 or 15 (frame or stack pointer). Otherwise it is low.
- R9: res_wrapped_o[c] is high exactly when the result was folded. A folded result always lies within the bounds.
- R10: While rst_ni is low, and in the first cycle after reset, res_valid_o, res_addr_o and res_wrapped_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | NCTX | Enable for each context |
| cfg_sel_i | input | NCTX*RW | Watched register number for each context |
| cfg_lo_i | input | NCTX*AW | Lower buffer bound for each context |
| cfg_hi_i | input | NCTX*AW | Upper buffer bound for each context |
| cfg_mode_i | input | NCTX*2 | Direction mode for each context |
| req_valid_i | input | NCTX | Update request for each context |
| req_reg_i | input | NCTX*RW | Register being updated |
| req_addr_i | input | NCTX*AW | Current pointer value |
| req_dec_i | input | NCTX | 1 = subtract the step, 0 = add it |
| req_step_i | input | NCTX*SW | Step magnitude, at most the buffer length |
| res_valid_o | output | NCTX | Result valid |
| res_addr_o | output | NCTX*AW | Updated pointer value |
| res_wrapped_o | output | NCTX | Result was folded at a bound |
| cfg_warn_o | output | NCTX | Frame or stack pointer selected |
| cfg_bad_o | output | NCTX | Context configuration rejected |

## Verification
The bench aims at the exact-bound cases: a sum landing on the upper bound or a difference landing on the lower bound must not wrap, while a step one further must land on the opposite bound. A design with an off-by-one compare would fold early and return the opposite bound. An off-by-one in the folding arithmetic would return an address one past a bound. Opposite-direction steps in single-direction modes, bidirectional mode with lengths of 6 and 8, and disabled or mismatched contexts are driven to expose a design that wraps where it should pass through. The bench also drives both contexts with different configurations at the same time to catch crosstalk between slices.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DN   = 2'b01,
    MODE_BI   = 2'b10,
    MODE_RSV  = 2'b11
  } wrap_mode_e;
endpackage

// File: rtl/mod_len_chk.sv
module mod_len_chk
  import modaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [1:0]    mode_i,
  output logic          cfg_ok_o,
  output logic          up_act_o,
  output logic          dn_act_o
);
  logic [AW:0] len;
  logic        rng_ok, pow2;

  assign rng_ok = hi_i >= lo_i;
  assign len    = {1'b0, hi_i} - {1'b0, lo_i} + (AW+1)'(1);
  assign pow2   = (len != '0) && ((len & (len - (AW+1)'(1))) == '0);

  always_comb begin
    up_act_o = 1'b0;
    dn_act_o = 1'b0;
    cfg_ok_o = rng_ok;
    unique case (wrap_mode_e'(mode_i))
      MODE_UP:  up_act_o = 1'b1;
      MODE_DN:  dn_act_o = 1'b1;
      MODE_BI: begin
        up_act_o = 1'b1;
        dn_act_o = 1'b1;
        cfg_ok_o = rng_ok & pow2;
      end
      default:  cfg_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mod_wrap_calc.sv
module mod_wrap_calc #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] step_i,
  input  logic          dec_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          up_chk_i,
  input  logic          dn_chk_i,
  output logic [AW-1:0] nxt_o,
  output logic          wrapped_o
);
  logic [AW:0] step_x, sum, lo_plus;
  logic [AW-1:0] diff;

  assign step_x  = (AW+1)'(step_i);
  assign sum     = {1'b0, addr_i} + step_x;
  assign diff    = addr_i - AW'(step_i);
  assign lo_plus = {1'b0, lo_i} + step_x;

  always_comb begin
    wrapped_o = 1'b0;
    if (!dec_i) begin
      nxt_o = sum[AW-1:0];
      if (up_chk_i && (sum > {1'b0, hi_i})) begin
        // fold overshoot past upper bound onto lower bound
        nxt_o     = lo_i + AW'(sum - {1'b0, hi_i} - (AW+1)'(1));
        wrapped_o = 1'b1;
      end
    end else begin
      nxt_o = diff;
      if (dn_chk_i && ({1'b0, addr_i} < lo_plus)) begin
        nxt_o     = hi_i - (lo_i - diff - AW'(1));
        wrapped_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/circ_addr_unit.sv
module circ_addr_unit #(
  parameter int NCTX   = 2,
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int SW     = 4,
  parameter int FP_REG = 14,
  parameter int SP_REG = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCTX-1:0]    cfg_en_i,
  input  logic [NCTX*RW-1:0] cfg_sel_i,
  input  logic [NCTX*AW-1:0] cfg_lo_i,
  input  logic [NCTX*AW-1:0] cfg_hi_i,
  input  logic [NCTX*2-1:0]  cfg_mode_i,
  input  logic [NCTX-1:0]    req_valid_i,
  input  logic [NCTX*RW-1:0] req_reg_i,
  input  logic [NCTX*AW-1:0] req_addr_i,
  input  logic [NCTX-1:0]    req_dec_i,
  input  logic [NCTX*SW-1:0] req_step_i,
  output logic [NCTX-1:0]    res_valid_o,
  output logic [NCTX*AW-1:0] res_addr_o,
  output logic [NCTX-1:0]    res_wrapped_o,
  output logic [NCTX-1:0]    cfg_warn_o,
  output logic [NCTX-1:0]    cfg_bad_o
);
  localparam logic [RW-1:0] FP_SEL = RW'(FP_REG);
  localparam logic [RW-1:0] SP_SEL = RW'(SP_REG);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [AW-1:0] lo, hi, nxt;
    logic [RW-1:0] sel;
    logic          cfg_ok, up_act, dn_act, hit, wrapped;

    assign lo  = cfg_lo_i[c*AW +: AW];
    assign hi  = cfg_hi_i[c*AW +: AW];
    assign sel = cfg_sel_i[c*RW +: RW];

    mod_len_chk #(.AW(AW)) u_len (
      .lo_i     (lo),
      .hi_i     (hi),
      .mode_i   (cfg_mode_i[c*2 +: 2]),
      .cfg_ok_o (cfg_ok),
      .up_act_o (up_act),
      .dn_act_o (dn_act)
    );

    assign hit = cfg_en_i[c] & cfg_ok & (req_reg_i[c*RW +: RW] == sel);

    mod_wrap_calc #(.AW(AW), .SW(SW)) u_wrap (
      .addr_i    (req_addr_i[c*AW +: AW]),
      .step_i    (req_step_i[c*SW +: SW]),
      .dec_i     (req_dec_i[c]),
      .lo_i      (lo),
      .hi_i      (hi),
      .up_chk_i  (hit & up_act),
      .dn_chk_i  (hit & dn_act),
      .nxt_o     (nxt),
      .wrapped_o (wrapped)
    );

    assign cfg_warn_o[c] = cfg_en_i[c] & ((sel == FP_SEL) | (sel == SP_SEL));
    assign cfg_bad_o[c]  = cfg_en_i[c] & ~cfg_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_valid_o[c]          <= 1'b0;
        res_addr_o[c*AW +: AW]  <= '0;
        res_wrapped_o[c]        <= 1'b0;
      end else begin
        res_valid_o[c] <= req_valid_i[c];
        if (req_valid_i[c]) begin
          res_addr_o[c*AW +: AW] <= nxt;
          res_wrapped_o[c]       <= wrapped;
        end else begin
          res_wrapped_o[c]       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/circ_addr_chk.sv
module circ_addr_chk #(
  parameter int NCTX = 2,
  parameter int AW   = 16,
  parameter int RW   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCTX-1:0]    cfg_en_i,
  input logic [NCTX*AW-1:0] cfg_lo_i,
  input logic [NCTX*AW-1:0] cfg_hi_i,
  input logic [NCTX-1:0]    req_valid_i,
  input logic [NCTX-1:0]    res_valid_o,
  input logic [NCTX*AW-1:0] res_addr_o,
  input logic [NCTX-1:0]    res_wrapped_o,
  input logic [NCTX-1:0]    cfg_warn_o,
  input logic [NCTX-1:0]    cfg_bad_o
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_chk
    // R1
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started |-> (res_valid_o[c] == $past(req_valid_i[c])));
    // R9
    wrap_in_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o[c] && res_wrapped_o[c]) |->
        (res_addr_o[c*AW +: AW] >= $past(cfg_lo_i[c*AW +: AW])) &&
        (res_addr_o[c*AW +: AW] <= $past(cfg_hi_i[c*AW +: AW])));
    // R9
    wrap_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !res_valid_o[c] |-> !res_wrapped_o[c]);
    // R6
    bad_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o[c] && $past(cfg_bad_o[c])) |-> !res_wrapped_o[c]);
    // R7
    off_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o[c] && !$past(cfg_en_i[c])) |-> !res_wrapped_o[c]);
    // R8
    warn_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i[c] |-> !cfg_warn_o[c] && !cfg_bad_o[c]);
  end

  // R10
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (res_valid_o == '0 && res_wrapped_o == '0);
    end
  end
endmodule

bind circ_addr_unit circ_addr_chk #(.NCTX(NCTX), .AW(AW), .RW(RW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_en_i      (cfg_en_i),
  .cfg_lo_i      (cfg_lo_i),
  .cfg_hi_i      (cfg_hi_i),
  .req_valid_i   (req_valid_i),
  .res_valid_o   (res_valid_o),
  .res_addr_o    (res_addr_o),
  .res_wrapped_o (res_wrapped_o),
  .cfg_warn_o    (cfg_warn_o),
  .cfg_bad_o     (cfg_bad_o)
);

// File: tb/circ_addr_unit_tb_top.sv
module circ_addr_unit_tb_top;
  localparam int NCTX = 2, AW = 16, RW = 4, SW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCTX-1:0]    cfg_en_i = '0, req_valid_i = '0, req_dec_i = '0;
  logic [NCTX*RW-1:0] cfg_sel_i = '0, req_reg_i = '0;
  logic [NCTX*AW-1:0] cfg_lo_i = '0, cfg_hi_i = '0, req_addr_i = '0;
  logic [NCTX*2-1:0]  cfg_mode_i = '0;
  logic [NCTX*SW-1:0] req_step_i = '0;
  logic [NCTX-1:0]    res_valid_o, res_wrapped_o, cfg_warn_o, cfg_bad_o;
  logic [NCTX*AW-1:0] res_addr_o;

  circ_addr_unit #(.NCTX(NCTX), .AW(AW), .RW(RW), .SW(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_sel_i(cfg_sel_i),
    .cfg_lo_i(cfg_lo_i), .cfg_hi_i(cfg_hi_i), .cfg_mode_i(cfg_mode_i),
    .req_valid_i(req_valid_i), .req_reg_i(req_reg_i), .req_addr_i(req_addr_i),
    .req_dec_i(req_dec_i), .req_step_i(req_step_i), .res_valid_o(res_valid_o),
    .res_addr_o(res_addr_o), .res_wrapped_o(res_wrapped_o),
    .cfg_warn_o(cfg_warn_o), .cfg_bad_o(cfg_bad_o));

  int errs = 0, checks = 0;
  int m_en[NCTX], m_sel[NCTX], m_lo[NCTX], m_hi[NCTX], m_mode[NCTX];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int c, int en, int sel, int lo, int hi, int mode);
    m_en[c] = en; m_sel[c] = sel; m_lo[c] = lo; m_hi[c] = hi; m_mode[c] = mode;
    cfg_en_i[c] = en[0];
    cfg_sel_i[c*RW +: RW] = RW'(sel);
    cfg_lo_i[c*AW +: AW] = AW'(lo);
    cfg_hi_i[c*AW +: AW] = AW'(hi);
    cfg_mode_i[c*2 +: 2] = 2'(mode);
  endtask

  function automatic bit is_pow2(int n);
    return n > 0 && (n & (n - 1)) == 0;
  endfunction

  function automatic bit exp_bad(int c);
    if (!m_en[c]) return 0;
    return (m_hi[c] < m_lo[c]) || (m_mode[c] == 3) ||
           (m_mode[c] == 2 && !is_pow2(m_hi[c] - m_lo[c] + 1));
  endfunction

  // returns {wrapped, addr}
  function automatic int model(int c, int rg, int addr, int dec, int step);
    bit hit = m_en[c] && (m_sel[c] == rg) && !exp_bad(c);
    bit up  = m_mode[c] == 0 || m_mode[c] == 2;
    bit dn  = m_mode[c] == 1 || m_mode[c] == 2;
    int n;
    if (!dec) begin
      n = addr + step;
      if (hit && up && n > m_hi[c]) return (1 << 16) | (m_lo[c] + (n - m_hi[c] - 1));
    end else begin
      n = addr - step;
      if (hit && dn && n < m_lo[c]) return (1 << 16) | (m_hi[c] - (m_lo[c] - n - 1));
    end
    return n & 16'hFFFF;
  endfunction

  // drive one request on context c, check result one cycle later
  task automatic op(string tag, int c, int rg, int addr, int dec, int step);
    int e;
    req_valid_i = '0;
    req_valid_i[c] = 1'b1;
    req_reg_i[c*RW +: RW] = RW'(rg);
    req_addr_i[c*AW +: AW] = AW'(addr);
    req_dec_i[c] = dec[0];
    req_step_i[c*SW +: SW] = SW'(step);
    e = model(c, rg, addr, dec, step);
    @(posedge clk); #1;
    req_valid_i = '0;
    chk({tag, " R1 valid"}, int'(res_valid_o[c]), 1);
    chk({tag, " addr"}, int'(res_addr_o[c*AW +: AW]), e & 16'hFFFF);
    chk({tag, " R9 wrapped"}, int'(res_wrapped_o[c]), e >> 16);
  endtask

  initial begin : watchdog
    #(5 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCTX; c++) set_cfg(c, 0, 0, 0, 0, 0);
    #12;
    // R10 reset state
    chk("R10 valid", int'(res_valid_o), 0);
    chk("R10 addr", int'(res_addr_o), 0);
    chk("R10 wrapped", int'(res_wrapped_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R10 first cycle valid", int'(res_valid_o), 0);

    // X: upward 0x100..0x10F on reg 8; Y: downward 0x200..0x205 on reg 10
    set_cfg(0, 1, 8, 'h100, 'h10F, 0);
    set_cfg(1, 1, 10, 'h200, 'h205, 1);
    #1;
    chk("R8 no warn", int'(cfg_warn_o), 0);
    chk("R6 good cfg", int'(cfg_bad_o), 0);
    op("R2 land on hi", 0, 8, 'h10D, 0, 2);
    op("R2 one past hi", 0, 8, 'h10E, 0, 2);
    op("R2 overshoot 3", 0, 8, 'h10F, 0, 3);
    op("R4 up-only dec pass", 0, 8, 'h100, 1, 2);
    op("R3 land on lo", 1, 10, 'h202, 1, 2);
    op("R3 one below lo", 1, 10, 'h201, 1, 2);
    op("R3 undershoot 4", 1, 10, 'h200, 1, 4);
    op("R4 dn-only inc pass", 1, 10, 'h205, 0, 3);
    op("R7 reg mismatch", 0, 9, 'h10F, 0, 1);
    // R1 independence: both contexts in one cycle
    req_valid_i = 2'b11;
    req_reg_i = {4'd10, 4'd8}; req_addr_i = {16'h200, 16'h10F};
    req_dec_i = 2'b10; req_step_i = {4'd1, 4'd1};
    @(posedge clk); #1; req_valid_i = '0;
    chk("R1 ctx0 addr", int'(res_addr_o[15:0]), 'h100);
    chk("R1 ctx1 addr", int'(res_addr_o[31:16]), 'h205);
    chk("R1 both wrapped", int'(res_wrapped_o), 3);
    @(posedge clk); #1;
    chk("R1 valid drops", int'(res_valid_o), 0);

    // R7 disabled
    set_cfg(0, 0, 8, 'h100, 'h10F, 0);
    op("R7 disabled", 0, 8, 'h10F, 0, 1);
    // R5 bidirectional power of two, length 8
    set_cfg(0, 1, 3, 'h40, 'h47, 2);
    op("R5 bi up", 0, 3, 'h46, 0, 3);
    op("R5 bi down", 0, 3, 'h41, 1, 3);
    // R6 bidirectional length 6 rejected
    set_cfg(1, 1, 5, 'h40, 'h45, 2); #1;
    chk("R6 bad non-pow2", int'(cfg_bad_o[1]), 1);
    op("R6 bad pass up", 1, 5, 'h45, 0, 2);
    op("R6 bad pass down", 1, 5, 'h40, 1, 1);
    set_cfg(1, 1, 5, 'h50, 'h40, 0); #1;
    chk("R6 bad reversed", int'(cfg_bad_o[1]), 1);
    set_cfg(1, 1, 5, 'h40, 'h47, 3); #1;
    chk("R6 bad reserved", int'(cfg_bad_o[1]), 1);
    // R8 warnings
    set_cfg(0, 1, 14, 'h40, 'h47, 0);
    set_cfg(1, 1, 15, 'h40, 'h47, 1); #1;
    chk("R8 warn fp/sp", int'(cfg_warn_o), 3);
    set_cfg(1, 0, 15, 'h40, 'h47, 1); #1;
    chk("R8 warn needs enable", int'(cfg_warn_o), 1);
    op("R2 wrap on reg 14", 0, 14, 'h47, 0, 1);

    // random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      int c, lo, len, mode, sel, rg, addr, step;
      c = int'($urandom_range(1, 0));
      lo = int'($urandom_range(16'hF000, 0));
      len = ($urandom_range(3, 0) == 0) ? (1 << $urandom_range(6, 1))
                                        : int'($urandom_range(64, 1));
      mode = int'($urandom_range(3, 0));
      sel = int'($urandom_range(15, 0));
      set_cfg(c, int'($urandom_range(7, 0) != 0), sel, lo, lo + len - 1, mode);
      rg = ($urandom_range(4, 0) != 0) ? sel : int'($urandom_range(15, 0));
      addr = lo + int'($urandom_range(len - 1, 0));
      step = int'($urandom_range((len < 15) ? len : 15, 0));
      #1;
      chk("R6 rand bad", int'(cfg_bad_o[c]), int'(exp_bad(c)));
      op("R2/R3/R5 rand", c, rg, addr, int'($urandom_range(1, 0)), step);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule